// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number and an offset, into a physical address. It holds a small table of segment descriptors and a register that sets how many of them are in use. Each descriptor gives a starting physical address, a length, a flag that marks the segment as usable, and three permission bits for read, write and execute. All of this state is loaded through a configuration port. It is reset to an empty table with a length of zero.

Every request is checked in a fixed order. The segment number must fall below the table length. The descriptor must be marked usable. The offset must be below the segment length. The access kind must be allowed by the permission bits. A request that passes all four checks returns the start address plus the offset. A request that fails any check returns a trap flag and a cause code, with the physical address forced to zero. The result is registered and appears on the cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset the outputs are all zero (`rsp_valid`, `rsp_trap`, `rsp_cause`, `rsp_paddr`). The table length is 0 and every descriptor is unusable, so any request traps with cause 1.
- R2: `rsp_valid` is high on exactly the cycle after a cycle in which `req_valid` was high, and low otherwise.
- R3: A request whose segment number is not strictly below the table length traps with cause 1.
- R4: A request to a descriptor whose usable flag is 0 traps with cause 2.
- R5: A request whose offset is greater than or equal to the segment length traps with cause 3. An offset of length minus one is legal.
- R6: Access kind encoding is 00 read, 01 write, 10 execute and 11 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. An access kind whose bit is clear traps with cause 4. The reserved kind always traps with cause 4.
- R7: A request that passes every check gives trap 0, cause 0 and a physical address of start plus offset, taken modulo 2^PA_W.
- R8: When several checks fail, the lowest cause number is reported (1 before 2 before 3 before 4).
- R9: `rsp_trap` is 1 exactly when `rsp_cause` is not 0. On a trap, `rsp_paddr` is 0.
- R10: A descriptor write or a length write in the same cycle as a request does not affect that request. It takes effect from the next request.
- R11: In a cycle without a request, `rsp_trap`, `rsp_cause` and `rsp_paddr` keep their previous values.
- R12: A length write above the number of table entries (2^SEG_W) stores that number instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one descriptor |
| cfg_idx | input | SEG_W | Descriptor index to write |
| cfg_base | input | PA_W | Start physical address of the segment |
| cfg_limit | input | OFF_W+1 | Segment length |
| cfg_usable | input | 1 | Usable flag |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| len_we | input | 1 | Write the table length |
| len_val | input | SEG_W+1 | New table length |
| req_valid | input | 1 | Translation request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset in the segment |
| req_acc | input | 2 | Access kind |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_trap | output | 1 | Trap raised |
| rsp_cause | output | 3 | Cause: 0 none, 1 range, 2 unusable, 3 length, 4 permission |
| rsp_paddr | output | PA_W | Physical address, zero on a trap |

## Verification
The hardest case to reach is a configuration write that lands in the same cycle as a request that reads the same descriptor or the length. From the ports this looks exactly like an ordinary write followed by a request. The bench therefore raises `cfg_we` or `len_we` on the same falling edge as `req_valid`. It expects the old descriptor's result first and the new one on the following request. Cause priority is reached by building a request that breaks two or three checks at once. This is done against descriptors set up for that purpose, and by shrinking the length so that a segment that is both unusable and out of range is reported as out of range.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    // Trap causes; the numeric order is the reporting priority.
    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_RANGE   = 3'd1,
        CAUSE_UNUSED  = 3'd2,
        CAUSE_LENGTH  = 3'd3,
        CAUSE_PERM    = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 10,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFF_W:0]   cfg_limit,
    input  logic             cfg_usable,
    input  logic [2:0]       cfg_perm,
    input  logic             len_we,
    input  logic [SEG_W:0]   len_val,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W:0]   rd_limit,
    output logic             rd_usable,
    output logic [2:0]       rd_perm,
    output logic [SEG_W:0]   seg_len
);

    localparam int NSEG  = 1 << SEG_W;
    localparam int LEN_W = SEG_W + 1;
    localparam int LIM_W = OFF_W + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(NSEG);

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [LIM_W-1:0] limit;
        logic             usable;
        logic [2:0]       perm;
    } desc_t;

    desc_t            desc_d [NSEG];
    desc_t            desc_q [NSEG];
    logic [LEN_W-1:0] len_d;
    logic [LEN_W-1:0] len_q;
    logic [NSEG-1:0]  wr_hit;

    // One write-enable per descriptor slot.
    for (genvar g = 0; g < NSEG; g++) begin : g_dec
        assign wr_hit[g] = cfg_we && (cfg_idx == SEG_W'(g));
    end

    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            desc_d[i] = desc_q[i];
            if (wr_hit[i]) begin
                desc_d[i].base   = cfg_base;
                desc_d[i].limit  = cfg_limit;
                desc_d[i].usable = cfg_usable;
                desc_d[i].perm   = cfg_perm;
            end
        end
        len_d = len_q;
        if (len_we) begin
            len_d = (len_val > LEN_MAX) ? LEN_MAX : len_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                desc_q[i] <= '0;
            end
            len_q <= '0;
        end else begin
            for (int i = 0; i < NSEG; i++) begin
                desc_q[i] <= desc_d[i];
            end
            len_q <= len_d;
        end
    end

    // Read port reflects registered contents only (write lands next cycle).
    assign rd_base   = desc_q[rd_idx].base;
    assign rd_limit  = desc_q[rd_idx].limit;
    assign rd_usable = desc_q[rd_idx].usable;
    assign rd_perm   = desc_q[rd_idx].perm;
    assign seg_len   = len_q;

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        seg_len <= LEN_MAX);  // R12

    AST_LEN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (len_we && len_val > LEN_MAX) |=> (seg_len == LEN_MAX));  // R12

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 10
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       acc,
    input  logic [SEG_W:0]   seg_len,
    input  logic             usable,
    input  logic [OFF_W:0]   limit,
    input  logic [2:0]       perm,
    output cause_e           cause
);

    logic in_range;
    logic in_length;
    logic allowed;

    always_comb begin
        in_range  = {1'b0, seg} < seg_len;
        in_length = {1'b0, off} < limit;
        unique case (acc_e'(acc))
            ACC_READ:  allowed = perm[PERM_RD];
            ACC_WRITE: allowed = perm[PERM_WR];
            ACC_EXEC:  allowed = perm[PERM_EX];
            default:   allowed = 1'b0;
        endcase

        // Priority: lowest cause number wins.
        if (!in_range) begin
            cause = CAUSE_RANGE;
        end else if (!usable) begin
            cause = CAUSE_UNUSED;
        end else if (!in_length) begin
            cause = CAUSE_LENGTH;
        end else if (!allowed) begin
            cause = CAUSE_PERM;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
    parameter int OFF_W = 10,
    parameter int PA_W  = 16
) (
    input  logic [PA_W-1:0]  base,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  sum
);

    logic [PA_W-1:0] off_ext;

    if (PA_W > OFF_W) begin : g_ext
        assign off_ext = {{(PA_W-OFF_W){1'b0}}, off};
    end else begin : g_same
        assign off_ext = off[PA_W-1:0];
    end

    assign sum = base + off_ext;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 10,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEG_W-1:0] cfg_idx,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [OFF_W:0]   cfg_limit,
    input  logic             cfg_usable,
    input  logic [2:0]       cfg_perm,
    input  logic             len_we,
    input  logic [SEG_W:0]   len_val,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic             rsp_trap,
    output logic [2:0]       rsp_cause,
    output logic [PA_W-1:0]  rsp_paddr
);

    typedef struct packed {
        logic            valid;
        logic            trap;
        cause_e          cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t            rsp_d;
    rsp_t            rsp_q;
    logic [PA_W-1:0] ent_base;
    logic [OFF_W:0]  ent_limit;
    logic            ent_usable;
    logic [2:0]      ent_perm;
    logic [SEG_W:0]  seg_len;
    cause_e          chk_cause;
    logic [PA_W-1:0] sum;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_base   (cfg_base),
        .cfg_limit  (cfg_limit),
        .cfg_usable (cfg_usable),
        .cfg_perm   (cfg_perm),
        .len_we     (len_we),
        .len_val    (len_val),
        .rd_idx     (req_seg),
        .rd_base    (ent_base),
        .rd_limit   (ent_limit),
        .rd_usable  (ent_usable),
        .rd_perm    (ent_perm),
        .seg_len    (seg_len)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W)) check_i (
        .seg     (req_seg),
        .off     (req_off),
        .acc     (req_acc),
        .seg_len (seg_len),
        .usable  (ent_usable),
        .limit   (ent_limit),
        .perm    (ent_perm),
        .cause   (chk_cause)
    );

    seg_adder #(.OFF_W(OFF_W), .PA_W(PA_W)) adder_i (
        .base (ent_base),
        .off  (req_off),
        .sum  (sum)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.cause = chk_cause;
            rsp_d.trap  = (chk_cause != CAUSE_NONE);
            rsp_d.paddr = (chk_cause == CAUSE_NONE) ? sum : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '{valid: 1'b0, trap: 1'b0, cause: CAUSE_NONE, paddr: '0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_trap  = rsp_q.trap;
    assign rsp_cause = rsp_q.cause;
    assign rsp_paddr = rsp_q.paddr;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R2

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);  // R2

    AST_RANGE_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_seg} >= seg_len)) |=> (rsp_cause == 3'd1));  // R3

    AST_TRAP_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (rsp_paddr == '0 && rsp_cause != 3'd0));  // R9

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cause <= 3'd4);  // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_cause) && $stable(rsp_paddr) && $stable(rsp_trap)));  // R11

endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb_top;

    localparam int SEG_W = 3;
    localparam int OFF_W = 10;
    localparam int PA_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [SEG_W-1:0] cfg_idx = '0;
    logic [PA_W-1:0]  cfg_base = '0;
    logic [OFF_W:0]   cfg_limit = '0;
    logic             cfg_usable = 1'b0;
    logic [2:0]       cfg_perm = '0;
    logic             len_we = 1'b0;
    logic [SEG_W:0]   len_val = '0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic             rsp_valid;
    logic             rsp_trap;
    logic [2:0]       rsp_cause;
    logic [PA_W-1:0]  rsp_paddr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_usable(cfg_usable), .cfg_perm(cfg_perm),
        .len_we(len_we), .len_val(len_val),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; leaves at a falling edge.
    task automatic write_desc(input int idx, input int base, input int lim,
                              input bit usable, input logic [2:0] perm);
        cfg_we = 1'b1; cfg_idx = SEG_W'(idx); cfg_base = PA_W'(base);
        cfg_limit = (OFF_W+1)'(lim); cfg_usable = usable; cfg_perm = perm;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_len(input int v);
        len_we = 1'b1; len_val = (SEG_W+1)'(v);
        @(posedge clk); @(negedge clk);
        len_we = 1'b0;
    endtask

    // One request; checks valid, trap, cause and address one cycle later.
    task automatic do_req(input string tag, input int seg, input int off, input int acc,
                          input int exp_cause, input int exp_addr);
        req_valid = 1'b1; req_seg = SEG_W'(seg); req_off = OFF_W'(off); req_acc = 2'(acc);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b0; len_we = 1'b0;
        check({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " cause"}, 32'(rsp_cause), 32'(exp_cause));
        check({tag, " R9 trap"}, 32'(rsp_trap), 32'(exp_cause != 0));
        check({tag, " addr"}, 32'(rsp_paddr), (exp_cause != 0) ? 32'd0 : 32'(exp_addr));
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(rsp_valid), 32'd0);
        check("R1 trap", 32'(rsp_trap), 32'd0);
        check("R1 cause", 32'(rsp_cause), 32'd0);
        check("R1 addr", 32'(rsp_paddr), 32'd0);
        do_req("R1 empty table", 0, 0, 0, 1, 0);
    endtask

    task automatic t_setup();
        write_len(4);
        write_desc(0, 'h1000, 'h100, 1'b1, 3'b101);  // read+exec
        write_desc(1, 'h2000, 'h400, 1'b1, 3'b011);  // read+write, full length
        write_desc(2, 'h3000, 'h010, 1'b0, 3'b111);  // unusable
        write_desc(3, 'hFF00, 'h200, 1'b1, 3'b010);  // write only, wraps
    endtask

    task automatic t_legal();
        do_req("R7 seg0 read last", 0, 'h0FF, 0, 0, 'h10FF);
        do_req("R7 seg0 exec", 0, 5, 2, 0, 'h1005);
        do_req("R7 seg1 write top", 1, 'h3FF, 1, 0, 'h23FF);
        do_req("R7 seg3 wrap", 3, 'h1FF, 1, 0, 'h00FF);
    endtask

    task automatic t_range();
        do_req("R3 seg4", 4, 0, 0, 1, 0);
        do_req("R3 seg7", 7, 0, 0, 1, 0);
    endtask

    task automatic t_unusable();
        do_req("R4 seg2", 2, 0, 0, 2, 0);
    endtask

    task automatic t_length();
        do_req("R5 seg0 at limit", 0, 'h100, 0, 3, 0);
        do_req("R5 seg3 beyond", 3, 'h3FF, 1, 3, 0);
    endtask

    task automatic t_perm();
        do_req("R6 seg0 write", 0, 1, 1, 4, 0);
        do_req("R6 seg1 exec", 1, 1, 2, 4, 0);
        do_req("R6 seg3 read", 3, 1, 0, 4, 0);
        do_req("R6 reserved kind", 0, 1, 3, 4, 0);
    endtask

    task automatic t_priority();
        do_req("R8 unusable over length", 2, 'h3FF, 3, 2, 0);
        do_req("R8 length over perm", 0, 'h200, 1, 3, 0);
        write_len(2);
        do_req("R8 range over unusable", 2, 'h3FF, 3, 1, 0);
        write_len(4);
    endtask

    task automatic t_idle_hold();
        do_req("R11 prime", 1, 'h10, 0, 0, 'h2010);
        @(posedge clk); @(negedge clk);
        check("R2 idle no valid", 32'(rsp_valid), 32'd0);
        check("R11 addr held", 32'(rsp_paddr), 32'h2010);
        check("R11 cause held", 32'(rsp_cause), 32'd0);
    endtask

    task automatic t_same_cycle();
        // Descriptor write concurrent with request
        cfg_we = 1'b1; cfg_idx = 0; cfg_base = 16'h3000; cfg_limit = 11'h100;
        cfg_usable = 1'b1; cfg_perm = 3'b101;
        do_req("R10 old desc", 0, 1, 0, 0, 'h1001);
        do_req("R10 new desc", 0, 1, 0, 0, 'h3001);
        // Length write concurrent with request
        len_we = 1'b1; len_val = '0;
        do_req("R10 old length", 0, 2, 0, 0, 'h3002);
        do_req("R10 new length", 0, 2, 0, 1, 0);
        write_len(4);
    endtask

    task automatic t_len_sat();
        write_len(15);
        // Length saturates at 8: seg7 is in range, reaches unusable check.
        do_req("R12 saturated", 7, 0, 0, 2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_legal();
        t_range();
        t_unusable();
        t_length();
        t_perm();
        t_priority();
        t_idle_hold();
        t_same_cycle();
        t_len_sat();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule